// File: doc/BRIEF.md
# Shared-Storage Multi-Queue FIFO Controller

This block keeps several logical FIFO queues inside one shared word-wide RAM. All queues share one write data port and one read data port. A write queue identifier steers each incoming word to its queue. A separate read queue identifier picks the queue that is drained. The two ports act independently: they may name different queues, or the same queue, in the same cycle.

Each queue owns a contiguous RAM region, given by a base address and a depth. It also has its own almost-full and almost-empty thresholds and a count of the words it holds. The queue layout, the number of active queues and the thresholds arrive as parallel configuration inputs. These are captured only while reset is held low. A built-in default layout can be chosen instead, which splits the RAM evenly.

For the queue named on the write port the block reports full and almost-full. For the queue named on the read port it reports almost-empty. A read that is accepted returns its word one cycle later, flagged by a valid pulse. A partial-reset input empties a single queue, but only when that queue is named on both ports.

Top module: `mq_fifo_ctrl`

## Requirements
- R1: An accepted write stores `wr_data_i` in the queue named by `wr_qid_i`. An accepted read takes the oldest word of the queue named by `rd_qid_i`. The word appears on `rd_data_o` with `rd_valid_o` high on the cycle after the read; `rd_valid_o` is low otherwise.
- R2: The write and read ports are independent. Reads and writes to different queues in one cycle do not affect each other. A write and a read to the same non-empty queue in one cycle are both accepted.
- R3: `wr_full_o` is high when the write-selected queue holds as many words as its depth. A write to a full queue is dropped and stores nothing.
- R4: A read from an empty queue is dropped. `rd_valid_o` stays low on the next cycle and the queue's contents are unchanged.
- R5: `wr_almost_full_o` is high when count + almost-full threshold >= depth for the write-selected queue.
- R6: `rd_almost_empty_o` is high when count <= almost-empty threshold for the read-selected queue.
- R7: With `prst_i` high and `wr_qid_i == rd_qid_i`, that queue is emptied, and any write or read that cycle is dropped. With the identifiers different, `prst_i` has no effect.
- R8: Configuration is captured on every clock edge while `rst_n` is low and is held afterwards. If `cfg_default_i` is high, the captured layout is the default: every queue active, depth RAM_DEPTH/NUM_Q, base q*RAM_DEPTH/NUM_Q, and both thresholds DEF_THR. Otherwise the `cfg_*` inputs are captured.
- R9: A queue identifier >= the active queue count names an inactive queue. Writes and reads to it are dropped, and `wr_full_o` and `wr_almost_full_o` read 1 for it.
- R10: Each queue's pointers wrap from base+depth-1 back to base, and FIFO order is kept across the wrap.
- R11: After reset every queue is empty and `rd_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low master reset; configuration is captured while low |
| cfg_default_i | input | 1 | Select the built-in even split instead of the cfg_* inputs |
| cfg_nq_i | input | NQ_W | Number of active queues (1..NUM_Q) |
| cfg_base_i | input | NUM_Q*ADDR_W | Per-queue RAM base address, queue 0 in the low bits |
| cfg_depth_i | input | NUM_Q*CNT_W | Per-queue depth in words |
| cfg_af_thr_i | input | NUM_Q*CNT_W | Per-queue almost-full threshold |
| cfg_ae_thr_i | input | NUM_Q*CNT_W | Per-queue almost-empty threshold |
| wr_en_i | input | 1 | Write request |
| wr_qid_i | input | QID_W | Queue written |
| wr_data_i | input | DATA_W | Write data |
| rd_en_i | input | 1 | Read request |
| rd_qid_i | input | QID_W | Queue read |
| prst_i | input | 1 | Partial reset of the queue named on both ports |
| rd_data_o | output | DATA_W | Read data, valid with rd_valid_o |
| rd_valid_o | output | 1 | Read data valid, one cycle after an accepted read |
| wr_full_o | output | 1 | Write-selected queue is full or inactive |
| wr_almost_full_o | output | 1 | Write-selected queue is at or past its almost-full level |
| rd_almost_empty_o | output | 1 | Read-selected queue is at or below its almost-empty level |

## Verification
The flags depend only on the registered counts and the current queue identifiers. They therefore take the new value as soon as the clock edge that accepts a write, read or partial reset has passed. `rd_valid_o` and `rd_data_o` come from one register stage, so they also answer on the edge right after the read request. Each bench step drives its inputs at the falling edge, keeps them through the next rising edge, and samples all outputs one nanosecond later. The expected value for a step is the queue state after that edge, seen through the identifiers that are still applied.

// File: rtl/mq_pkg.sv
package mq_pkg;

    localparam int MQ_MAX_QUEUES = 32;

    typedef enum logic [1:0] {
        SLOT_IDLE = 2'd0,
        SLOT_PUSH = 2'd1,
        SLOT_POP  = 2'd2,
        SLOT_BOTH = 2'd3
    } slot_op_e;

endpackage

// File: rtl/mq_cfg.sv
module mq_cfg #(
    parameter int NUM_Q     = 4,
    parameter int RAM_DEPTH = 32,
    parameter int DEF_THR   = 2,
    parameter int ADDR_W    = 5,
    parameter int CNT_W     = 6,
    parameter int NQ_W      = 3
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              use_def_i,
    input  logic [NQ_W-1:0]                   nq_i,
    input  logic [NUM_Q*ADDR_W-1:0]           base_i,
    input  logic [NUM_Q*CNT_W-1:0]            depth_i,
    input  logic [NUM_Q*CNT_W-1:0]            af_i,
    input  logic [NUM_Q*CNT_W-1:0]            ae_i,
    output logic [NQ_W-1:0]                   nq_o,
    output logic [NUM_Q-1:0][ADDR_W-1:0]      base_o,
    output logic [NUM_Q-1:0][CNT_W-1:0]       depth_o,
    output logic [NUM_Q-1:0][CNT_W-1:0]       af_o,
    output logic [NUM_Q-1:0][CNT_W-1:0]       ae_o
);

    localparam int SLICE = RAM_DEPTH / NUM_Q;

    typedef struct packed {
        logic [NQ_W-1:0]              nq;
        logic [NUM_Q-1:0][ADDR_W-1:0] base;
        logic [NUM_Q-1:0][CNT_W-1:0]  depth;
        logic [NUM_Q-1:0][CNT_W-1:0]  af;
        logic [NUM_Q-1:0][CNT_W-1:0]  ae;
    } cfg_t;

    cfg_t cfg_d, cfg_q, def_cfg, usr_cfg;

    always_comb begin
        def_cfg.nq = NQ_W'(NUM_Q);
        usr_cfg.nq = nq_i;
    end

    for (genvar q = 0; q < NUM_Q; q++) begin : g_field
        always_comb begin
            def_cfg.base[q]  = ADDR_W'(q * SLICE);
            def_cfg.depth[q] = CNT_W'(SLICE);
            def_cfg.af[q]    = CNT_W'(DEF_THR);
            def_cfg.ae[q]    = CNT_W'(DEF_THR);
            usr_cfg.base[q]  = base_i[q*ADDR_W +: ADDR_W];
            usr_cfg.depth[q] = depth_i[q*CNT_W +: CNT_W];
            usr_cfg.af[q]    = af_i[q*CNT_W +: CNT_W];
            usr_cfg.ae[q]    = ae_i[q*CNT_W +: CNT_W];
        end
    end

    always_comb begin
        cfg_d = cfg_q;
        if (!rst_n) begin
            cfg_d = use_def_i ? def_cfg : usr_cfg;
        end
    end

    always_ff @(posedge clk) begin
        cfg_q <= cfg_d;
    end

    assign nq_o    = cfg_q.nq;
    assign base_o  = cfg_q.base;
    assign depth_o = cfg_q.depth;
    assign af_o    = cfg_q.af;
    assign ae_o    = cfg_q.ae;

endmodule

// File: rtl/mq_qslot.sv
module mq_qslot
    import mq_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  slot_op_e          op_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [CNT_W-1:0]  depth_i,
    output logic [ADDR_W-1:0] wptr_o,
    output logic [ADDR_W-1:0] rptr_o,
    output logic [CNT_W-1:0]  count_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] wptr;
        logic [ADDR_W-1:0] rptr;
        logic [CNT_W-1:0]  count;
    } slot_t;

    slot_t s_d, s_q;
    logic [ADDR_W-1:0] last;

    function automatic logic [ADDR_W-1:0] step_ptr(input logic [ADDR_W-1:0] p,
                                                    input logic [ADDR_W-1:0] lim,
                                                    input logic [ADDR_W-1:0] b);
        return (p == lim) ? b : p + ADDR_W'(1);
    endfunction

    always_comb begin
        last = base_i + ADDR_W'(depth_i - CNT_W'(1));
        s_d  = s_q;
        if (clr_i) begin
            s_d.wptr  = base_i;
            s_d.rptr  = base_i;
            s_d.count = '0;
        end else begin
            case (op_i)
                SLOT_PUSH: begin
                    s_d.wptr  = step_ptr(s_q.wptr, last, base_i);
                    s_d.count = s_q.count + CNT_W'(1);
                end
                SLOT_POP: begin
                    s_d.rptr  = step_ptr(s_q.rptr, last, base_i);
                    s_d.count = s_q.count - CNT_W'(1);
                end
                SLOT_BOTH: begin
                    s_d.wptr = step_ptr(s_q.wptr, last, base_i);
                    s_d.rptr = step_ptr(s_q.rptr, last, base_i);
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.wptr  <= base_i;
            s_q.rptr  <= base_i;
            s_q.count <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign wptr_o  = s_q.wptr;
    assign rptr_o  = s_q.rptr;
    assign count_o = s_q.count;

endmodule

// File: rtl/mq_ram.sv
module mq_ram #(
    parameter int DEPTH  = 32,
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              re_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o
);

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
        if (re_i) begin
            rdata_q <= mem_q[raddr_i];
        end
    end

    assign rdata_o = rdata_q;

endmodule

// File: rtl/mq_fifo_ctrl.sv
module mq_fifo_ctrl
    import mq_pkg::*;
#(
    parameter int NUM_Q     = 4,
    parameter int RAM_DEPTH = 32,
    parameter int DATA_W    = 16,
    parameter int DEF_THR   = 2,
    localparam int ADDR_W   = $clog2(RAM_DEPTH),
    localparam int CNT_W    = $clog2(RAM_DEPTH + 1),
    localparam int QID_W    = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
    localparam int NQ_W     = $clog2(NUM_Q + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_default_i,
    input  logic [NQ_W-1:0]         cfg_nq_i,
    input  logic [NUM_Q*ADDR_W-1:0] cfg_base_i,
    input  logic [NUM_Q*CNT_W-1:0]  cfg_depth_i,
    input  logic [NUM_Q*CNT_W-1:0]  cfg_af_thr_i,
    input  logic [NUM_Q*CNT_W-1:0]  cfg_ae_thr_i,
    input  logic                    wr_en_i,
    input  logic [QID_W-1:0]        wr_qid_i,
    input  logic [DATA_W-1:0]       wr_data_i,
    input  logic                    rd_en_i,
    input  logic [QID_W-1:0]        rd_qid_i,
    input  logic                    prst_i,
    output logic [DATA_W-1:0]       rd_data_o,
    output logic                    rd_valid_o,
    output logic                    wr_full_o,
    output logic                    wr_almost_full_o,
    output logic                    rd_almost_empty_o
);

    typedef struct packed {
        logic rd_valid;
    } top_t;

    top_t t_d, t_q;

    logic [NQ_W-1:0]              cfg_nq;
    logic [NUM_Q-1:0][ADDR_W-1:0] cfg_base;
    logic [NUM_Q-1:0][CNT_W-1:0]  cfg_depth, cfg_af, cfg_ae;
    logic [NUM_Q-1:0][ADDR_W-1:0] wptr, rptr;
    logic [NUM_Q-1:0][CNT_W-1:0]  cnt;

    logic [CNT_W-1:0]  wr_cnt, wr_depth, wr_af, rd_cnt, rd_ae;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic              wq_ok, rq_ok, prst_hit, push_ok, pop_ok;

    mq_cfg #(
        .NUM_Q(NUM_Q), .RAM_DEPTH(RAM_DEPTH), .DEF_THR(DEF_THR),
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .NQ_W(NQ_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .use_def_i(cfg_default_i), .nq_i(cfg_nq_i),
        .base_i(cfg_base_i), .depth_i(cfg_depth_i), .af_i(cfg_af_thr_i),
        .ae_i(cfg_ae_thr_i), .nq_o(cfg_nq), .base_o(cfg_base),
        .depth_o(cfg_depth), .af_o(cfg_af), .ae_o(cfg_ae)
    );

    // Selected-queue views for each port
    always_comb begin
        wr_cnt = '0; wr_depth = '0; wr_af = '0; wr_addr = '0;
        rd_cnt = '0; rd_ae = '0; rd_addr = '0;
        for (int q = 0; q < NUM_Q; q++) begin
            if (QID_W'(q) == wr_qid_i) begin
                wr_cnt   = cnt[q];
                wr_depth = cfg_depth[q];
                wr_af    = cfg_af[q];
                wr_addr  = wptr[q];
            end
            if (QID_W'(q) == rd_qid_i) begin
                rd_cnt  = cnt[q];
                rd_ae   = cfg_ae[q];
                rd_addr = rptr[q];
            end
        end
    end

    always_comb begin
        wq_ok    = (NQ_W + 1)'(wr_qid_i) < (NQ_W + 1)'(cfg_nq);
        rq_ok    = (NQ_W + 1)'(rd_qid_i) < (NQ_W + 1)'(cfg_nq);
        prst_hit = prst_i && (wr_qid_i == rd_qid_i);
        push_ok  = wr_en_i && wq_ok && (wr_cnt != wr_depth) && !prst_hit;
        pop_ok   = rd_en_i && rq_ok && (rd_cnt != '0) && !prst_hit;
        t_d          = t_q;
        t_d.rd_valid = pop_ok;
    end

    for (genvar q = 0; q < NUM_Q; q++) begin : g_slot
        slot_op_e op;
        logic     clr;
        always_comb begin
            clr = prst_hit && (wr_qid_i == QID_W'(q));
            op  = slot_op_e'({pop_ok  && (rd_qid_i == QID_W'(q)),
                              push_ok && (wr_qid_i == QID_W'(q))});
        end
        mq_qslot #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_slot (
            .clk(clk), .rst_n(rst_n), .clr_i(clr), .op_i(op),
            .base_i(cfg_base[q]), .depth_i(cfg_depth[q]),
            .wptr_o(wptr[q]), .rptr_o(rptr[q]), .count_o(cnt[q])
        );
    end

    mq_ram #(.DEPTH(RAM_DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
        .clk(clk), .we_i(push_ok), .waddr_i(wr_addr), .wdata_i(wr_data_i),
        .re_i(pop_ok), .raddr_i(rd_addr), .rdata_o(rd_data_o)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q.rd_valid <= 1'b0;
        end else begin
            t_q <= t_d;
        end
    end

    assign rd_valid_o        = t_q.rd_valid;
    assign wr_full_o         = !wq_ok || (wr_cnt == wr_depth);
    assign wr_almost_full_o  = !wq_ok ||
                               ((CNT_W + 1)'(wr_cnt) + (CNT_W + 1)'(wr_af) >= (CNT_W + 1)'(wr_depth));
    assign rd_almost_empty_o = !rq_ok || (rd_cnt <= rd_ae);

endmodule

// File: rtl/mq_fifo_ctrl_chk.sv
module mq_fifo_ctrl_chk #(
    parameter int QID_W = 2,
    parameter int NQ_W  = 3,
    parameter int CNT_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_en_i,
    input logic [QID_W-1:0] wr_qid_i,
    input logic [QID_W-1:0] rd_qid_i,
    input logic             prst_i,
    input logic             rd_valid_o,
    input logic             wr_full_o,
    input logic             wr_almost_full_o,
    input logic [NQ_W-1:0]  cfg_nq,
    input logic [CNT_W-1:0] rd_cnt
);

    logic past_ok;

    always_ff @(posedge clk) begin
        past_ok <= rst_n;
    end

    // R1
    valid_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && rd_valid_o) |-> $past(rd_en_i));

    // R3
    full_implies_af_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_full_o |-> wr_almost_full_o);

    // R4
    empty_read_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(rd_en_i && (rd_cnt == '0))) |-> !rd_valid_o);

    // R7
    prst_blocks_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(prst_i && (wr_qid_i == rd_qid_i))) |-> !rd_valid_o);

    // R9
    inactive_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((NQ_W + 1)'(wr_qid_i) >= (NQ_W + 1)'(cfg_nq)) |-> wr_full_o);

endmodule

bind mq_fifo_ctrl mq_fifo_ctrl_chk #(.QID_W(QID_W), .NQ_W(NQ_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_en_i(rd_en_i), .wr_qid_i(wr_qid_i),
    .rd_qid_i(rd_qid_i), .prst_i(prst_i), .rd_valid_o(rd_valid_o),
    .wr_full_o(wr_full_o), .wr_almost_full_o(wr_almost_full_o),
    .cfg_nq(cfg_nq), .rd_cnt(rd_cnt)
);

// File: tb/mq_fifo_ctrl_test.sv
module mq_fifo_ctrl_test;

    localparam int NUM_Q = 4, RAM_DEPTH = 32, DATA_W = 16, DEF_THR = 2;
    localparam int ADDR_W = 5, CNT_W = 6, QID_W = 2, NQ_W = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_default_i = 1'b1;
    logic [NQ_W-1:0] cfg_nq_i = '0;
    logic [NUM_Q*ADDR_W-1:0] cfg_base_i = '0;
    logic [NUM_Q*CNT_W-1:0] cfg_depth_i = '0, cfg_af_thr_i = '0, cfg_ae_thr_i = '0;
    logic wr_en_i = 1'b0, rd_en_i = 1'b0, prst_i = 1'b0;
    logic [QID_W-1:0] wr_qid_i = '0, rd_qid_i = '0;
    logic [DATA_W-1:0] wr_data_i = '0;
    logic [DATA_W-1:0] rd_data_o;
    logic rd_valid_o, wr_full_o, wr_almost_full_o, rd_almost_empty_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    mq_fifo_ctrl #(.NUM_Q(NUM_Q), .RAM_DEPTH(RAM_DEPTH), .DATA_W(DATA_W), .DEF_THR(DEF_THR)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_default_i(cfg_default_i), .cfg_nq_i(cfg_nq_i),
        .cfg_base_i(cfg_base_i), .cfg_depth_i(cfg_depth_i), .cfg_af_thr_i(cfg_af_thr_i),
        .cfg_ae_thr_i(cfg_ae_thr_i), .wr_en_i(wr_en_i), .wr_qid_i(wr_qid_i),
        .wr_data_i(wr_data_i), .rd_en_i(rd_en_i), .rd_qid_i(rd_qid_i), .prst_i(prst_i),
        .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o), .wr_full_o(wr_full_o),
        .wr_almost_full_o(wr_almost_full_o), .rd_almost_empty_o(rd_almost_empty_o)
    );

    typedef struct packed {
        logic              we;
        logic [1:0]        wq;
        logic [15:0]       wd;
        logic              re;
        logic [1:0]        rq;
        logic              full;
        logic              af;
        logic              ae;
        logic              val;
        logic [15:0]       data;
    } vec_t;

    // Default layout: depth 8, thresholds 2 (af at count>=6, ae at count<=2)
    localparam vec_t VECS [9] = '{
        '{1'b1, 2'd1, 16'hA001, 1'b0, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0000},
        '{1'b1, 2'd1, 16'hA002, 1'b0, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0000},
        '{1'b1, 2'd1, 16'hA003, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000},
        '{1'b1, 2'd2, 16'hB001, 1'b1, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 16'hA001},
        '{1'b1, 2'd2, 16'hB002, 1'b1, 2'd2, 1'b0, 1'b0, 1'b1, 1'b1, 16'hB001},
        '{1'b0, 2'd1, 16'h0000, 1'b1, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 16'hA002},
        '{1'b0, 2'd1, 16'h0000, 1'b1, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 16'hA003},
        '{1'b0, 2'd1, 16'h0000, 1'b1, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0000},
        '{1'b0, 2'd2, 16'h0000, 1'b1, 2'd2, 1'b0, 1'b0, 1'b1, 1'b1, 16'hB002}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic we, input logic [1:0] wq, input logic [15:0] wd,
                        input logic re, input logic [1:0] rq, input logic pr);
        @(negedge clk);
        wr_en_i = we; wr_qid_i = wq; wr_data_i = wd;
        rd_en_i = re; rd_qid_i = rq; prst_i = pr;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wr_en_i = 1'b0; rd_en_i = 1'b0; prst_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        step(1'b0, 2'd0, 16'h0, 1'b0, 2'd0, 1'b0);
        chk("R11 full after reset", wr_full_o, 0);
        chk("R11 af after reset", wr_almost_full_o, 0);
        chk("R11 ae after reset", rd_almost_empty_o, 1);
        chk("R11 valid after reset", rd_valid_o, 0);

        // R1 R2 R4 R6 vector table
        for (int i = 0; i < 9; i++) begin
            step(VECS[i].we, VECS[i].wq, VECS[i].wd, VECS[i].re, VECS[i].rq, 1'b0);
            chk("R2 full vec", wr_full_o, VECS[i].full);
            chk("R5 af vec", wr_almost_full_o, VECS[i].af);
            chk("R6 ae vec", rd_almost_empty_o, VECS[i].ae);
            chk("R1 valid vec", rd_valid_o, VECS[i].val);
            if (VECS[i].val) chk("R1 data vec", rd_data_o, VECS[i].data);
        end

        // R3 R5 R6 R8: fill queue 3 of the default layout (depth 8)
        for (int i = 0; i < 8; i++) begin
            step(1'b1, 2'd3, 16'hC000 + 16'(i), 1'b0, 2'd3, 1'b0);
            chk("R3 full fill", wr_full_o, (i + 1 == 8));
            chk("R5 af fill", wr_almost_full_o, (i + 1 >= 6));
            chk("R6 ae fill", rd_almost_empty_o, (i + 1 <= 2));
        end
        step(1'b1, 2'd3, 16'hC0FF, 1'b0, 2'd3, 1'b0);
        chk("R3 full holds", wr_full_o, 1);
        for (int i = 0; i < 8; i++) begin
            step(1'b0, 2'd3, 16'h0, 1'b1, 2'd3, 1'b0);
            chk("R3 drain valid", rd_valid_o, 1);
            chk("R3 drain data", rd_data_o, 16'hC000 + 16'(i));
        end
        step(1'b0, 2'd3, 16'h0, 1'b1, 2'd3, 1'b0);
        chk("R3 R4 dropped word absent", rd_valid_o, 0);

        // R10 wrap inside queue 0
        for (int i = 0; i < 5; i++) step(1'b1, 2'd0, 16'hD000 + 16'(i), 1'b0, 2'd0, 1'b0);
        for (int i = 0; i < 5; i++) begin
            step(1'b0, 2'd0, 16'h0, 1'b1, 2'd0, 1'b0);
            chk("R10 data pre", rd_data_o, 16'hD000 + 16'(i));
        end
        for (int i = 0; i < 7; i++) step(1'b1, 2'd0, 16'hE000 + 16'(i), 1'b0, 2'd0, 1'b0);
        for (int i = 0; i < 7; i++) begin
            step(1'b0, 2'd0, 16'h0, 1'b1, 2'd0, 1'b0);
            chk("R10 valid wrap", rd_valid_o, 1);
            chk("R10 data wrap", rd_data_o, 16'hE000 + 16'(i));
        end

        // R7 partial reset
        for (int i = 0; i < 3; i++) step(1'b1, 2'd0, 16'hF000 + 16'(i), 1'b0, 2'd0, 1'b0);
        step(1'b0, 2'd0, 16'h0, 1'b0, 2'd1, 1'b1);
        step(1'b0, 2'd0, 16'h0, 1'b1, 2'd0, 1'b0);
        chk("R7 mismatch ignored valid", rd_valid_o, 1);
        chk("R7 mismatch ignored data", rd_data_o, 16'hF000);
        step(1'b1, 2'd0, 16'h1234, 1'b1, 2'd0, 1'b1);
        chk("R7 read dropped", rd_valid_o, 0);
        chk("R7 ae after clear", rd_almost_empty_o, 1);
        step(1'b0, 2'd0, 16'h0, 1'b1, 2'd0, 1'b0);
        chk("R7 queue emptied", rd_valid_o, 0);

        // R8 R9 custom layout
        cfg_default_i = 1'b0;
        cfg_nq_i      = 3'd2;
        cfg_base_i    = {5'd12, 5'd7, 5'd3, 5'd0};
        cfg_depth_i   = {6'd4, 6'd4, 6'd4, 6'd3};
        cfg_af_thr_i  = {6'd1, 6'd1, 6'd1, 6'd1};
        cfg_ae_thr_i  = {6'd0, 6'd0, 6'd0, 6'd0};
        do_reset();
        step(1'b1, 2'd2, 16'h5555, 1'b1, 2'd2, 1'b0);
        chk("R9 inactive full", wr_full_o, 1);
        chk("R9 inactive af", wr_almost_full_o, 1);
        step(1'b0, 2'd2, 16'h0, 1'b1, 2'd2, 1'b0);
        chk("R9 inactive read dropped", rd_valid_o, 0);
        step(1'b1, 2'd0, 16'h7000, 1'b0, 2'd0, 1'b0);
        chk("R8 custom full 1", wr_full_o, 0);
        chk("R8 custom af 1", wr_almost_full_o, 0);
        chk("R6 custom ae 1", rd_almost_empty_o, 0);
        step(1'b1, 2'd0, 16'h7001, 1'b0, 2'd0, 1'b0);
        chk("R5 custom af 2", wr_almost_full_o, 1);
        chk("R8 custom full 2", wr_full_o, 0);
        step(1'b1, 2'd0, 16'h7002, 1'b0, 2'd0, 1'b0);
        chk("R8 custom full 3", wr_full_o, 1);
        cfg_default_i = 1'b1;
        step(1'b1, 2'd0, 16'h7003, 1'b1, 2'd1, 1'b0);
        chk("R8 config held", wr_full_o, 1);
        chk("R8 queue1 empty read", rd_valid_o, 0);
        for (int i = 0; i < 3; i++) begin
            step(1'b0, 2'd0, 16'h0, 1'b1, 2'd0, 1'b0);
            chk("R8 custom data", rd_data_o, 16'h7000 + 16'(i));
        end
        step(1'b0, 2'd0, 16'h0, 1'b1, 2'd0, 1'b0);
        chk("R8 custom depth enforced", rd_valid_o, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule